// File: doc/BRIEF.md
# Display Link Stress Pattern Generator

This block produces one 21-bit pixel word on every rising edge of the pixel clock. The word is built to make a display link toggle as hard as it can. In each of the three colour channels, the four lowest bits carry square waves at one half, one quarter, one eighth and one sixteenth of the pixel rate. The two top colour bits stay low. The three timing controls (line sync, frame sync, data enable) stay high.

All square waves come from a single 4-bit counter that runs freely while the enable input is high. A synchronous reset puts the pattern back at its starting phase. Pulling enable low freezes the word at its present value. The block is placed in front of a serializer, or of a panel interface under test, as a worst-case traffic source.

Top module: `stress_pattern_gen`

## Requirements
- R1: One clock edge after synchronous reset, every colour bit (word bits 0..17) is low. The word then reads 0x1C0000.
- R2: Bit 0 of each channel is a square wave with a period of 16 enabled pixel clocks. It is low for the first 8 words after reset.
- R3: Bit 1 of each channel has a period of 8 enabled clocks. It is low for the first 4 words after reset.
- R4: Bit 2 of each channel has a period of 4 enabled clocks. It is low for the first 2 words after reset.
- R5: Bit 3 of each channel inverts on every enabled clock. It is low in the first word after reset.
- R6: Bits 4 and 5 of each channel are always low.
- R7: Word bits 18, 19 and 20 (line sync, frame sync, data enable) are always high.
- R8: The channels are laid out as red in bits 0..5, green in bits 6..11 and blue in bits 12..17. All three carry the same 6-bit value in every cycle.
- R9: A clock edge with enable low leaves the word unchanged. Counting resumes from the frozen phase when enable returns high.
- R10: Reset wins over enable. An edge with both high gives the R1 word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| enable | input | 1 | Advance the pattern when high; freeze it when low |
| pixel_word | output | 21 | Pattern word: three 6-bit channels, then three control bits |

## Verification
Reset and enable can both be high at the same clock edge. Reset must win, and the colour bits must return to zero rather than step forward. The vector table drives this case twice: once in the middle of a running sequence with enable high, and once with enable low. After each, counting has to restart from zero. Wrap-around from phase 15 back to 0 is run without interruption. A freeze is placed in the middle of a run, and the count must continue from the held phase.

// File: rtl/stress_pattern_gen.sv
module stress_pattern_gen #(
  parameter int CHAN_W   = 6,
  parameter int NUM_CHAN = 3,
  parameter int CTRL_W   = 3,
  parameter int DIV_W    = 4
) (
  input  logic                                  clk,
  input  logic                                  rst,
  input  logic                                  enable,
  output logic [NUM_CHAN*CHAN_W+CTRL_W-1:0]     pixel_word
);
  localparam int COLOR_W = NUM_CHAN * CHAN_W;

  logic [DIV_W-1:0]  phase;
  logic [CHAN_W-1:0] chan_val;

  always_ff @(posedge clk) begin
    if (rst)         phase <= '0;
    else if (enable) phase <= phase + 1'b1;
  end

  // lowest channel bit takes the slowest divider tap
  genvar b, c;
  generate
    for (b = 0; b < CHAN_W; b++) begin : g_bit
      if (b < DIV_W) begin : g_wave
        assign chan_val[b] = phase[DIV_W-1-b];
      end else begin : g_low
        assign chan_val[b] = 1'b0;
      end
    end
    for (c = 0; c < NUM_CHAN; c++) begin : g_chan
      assign pixel_word[c*CHAN_W +: CHAN_W] = chan_val;
    end
  endgenerate

  assign pixel_word[COLOR_W +: CTRL_W] = '1;
endmodule

module stress_pattern_chk (
  input logic        clk,
  input logic        rst,
  input logic        enable,
  input logic [20:0] pixel_word
);
  p_reset_clear_r1: assert property (@(posedge clk) rst |=> pixel_word[17:0] == 18'd0);
  p_reset_wins_r10: assert property (@(posedge clk) (rst && enable) |=> pixel_word[17:0] == 18'd0);
  p_half_rate_r5: assert property (@(posedge clk) disable iff (rst)
    enable |=> pixel_word[3] != $past(pixel_word[3]));
  p_quarter_rate_r4: assert property (@(posedge clk) disable iff (rst)
    (enable && pixel_word[3]) |=> pixel_word[2] != $past(pixel_word[2]));
  p_quarter_hold_r4: assert property (@(posedge clk) disable iff (rst)
    (enable && !pixel_word[3]) |=> $stable(pixel_word[2]));
  p_freeze_r9: assert property (@(posedge clk) disable iff (rst)
    !enable |=> $stable(pixel_word));
  p_chan_match_r8: assert property (@(posedge clk) disable iff (rst)
    pixel_word[11:6] == pixel_word[5:0] && pixel_word[17:12] == pixel_word[5:0]);
  p_upper_low_r6: assert property (@(posedge clk) disable iff (rst)
    pixel_word[5:4] == 2'b00);
endmodule

bind stress_pattern_gen stress_pattern_chk u_chk (
  .clk(clk), .rst(rst), .enable(enable), .pixel_word(pixel_word)
);

// File: tb/stress_pattern_gen_tb.sv
module stress_pattern_gen_tb_top;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        enable = 1'b0;
  logic [20:0] pixel_word;

  int total = 0;
  int bad   = 0;
  bit done  = 0;

  stress_pattern_gen dut_i (.clk(clk), .rst(rst), .enable(enable), .pixel_word(pixel_word));

  always #(CLK_PERIOD/2) clk = ~clk;

  // {rst, enable, expected phase after the edge}
  localparam logic [5:0] VEC [0:23] = '{
    {2'b01, 4'd1},  {2'b01, 4'd2},  {2'b00, 4'd2},  {2'b01, 4'd3},
    {2'b01, 4'd4},  {2'b01, 4'd5},  {2'b01, 4'd6},  {2'b01, 4'd7},
    {2'b01, 4'd8},  {2'b01, 4'd9},  {2'b01, 4'd10}, {2'b01, 4'd11},
    {2'b01, 4'd12}, {2'b01, 4'd13}, {2'b01, 4'd14}, {2'b01, 4'd15},
    {2'b01, 4'd0},  {2'b00, 4'd0},  {2'b01, 4'd1},  {2'b11, 4'd0},
    {2'b01, 4'd1},  {2'b01, 4'd2},  {2'b10, 4'd0},  {2'b00, 4'd0}
  };

  function automatic logic [20:0] model(input logic [3:0] k);
    logic [5:0] ch;
    ch = {2'b00, k[0], k[1], k[2], k[3]};
    return {3'b111, ch, ch, ch};
  endfunction

  task automatic check(input string req, input logic [20:0] act, input logic [20:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  initial begin
    #(CLK_PERIOD * 5000);
    total++; bad++;
    $display("FAIL watchdog: actual=running expected=finished");
    finish_run();
  end

  initial begin
    logic [20:0] e;
    logic [20:0] prev;
    int t0, t1, t2, t3;
    @(negedge clk); rst = 1'b1; enable = 1'b1;
    @(negedge clk);
    check("R1", pixel_word, 21'h1C0000);
    rst = 1'b0;

    for (int i = 0; i < 24; i++) begin
      rst = VEC[i][5]; enable = VEC[i][4];
      @(negedge clk);
      e = model(VEC[i][3:0]);
      if (VEC[i][5])      check("R10", pixel_word, e);
      else if (!VEC[i][4]) check("R9", pixel_word, e);
      check("R2", {20'd0, pixel_word[0]}, {20'd0, e[0]});
      check("R3", {20'd0, pixel_word[1]}, {20'd0, e[1]});
      check("R4", {20'd0, pixel_word[2]}, {20'd0, e[2]});
      check("R5", {20'd0, pixel_word[3]}, {20'd0, e[3]});
      check("R6", {19'd0, pixel_word[5:4]}, 21'd0);
      check("R7", {18'd0, pixel_word[20:18]}, {18'd0, 3'b111});
      check("R8", {3'd0, pixel_word[17:12], pixel_word[11:6], pixel_word[5:0]},
                  {3'd0, e[5:0], e[5:0], e[5:0]});
    end

    // toggle counts over 32 enabled clocks, independent of phase
    rst = 1'b0; enable = 1'b1;
    prev = pixel_word; t0 = 0; t1 = 0; t2 = 0; t3 = 0;
    for (int i = 0; i < 32; i++) begin
      @(negedge clk);
      if (pixel_word[0] != prev[0]) t0++;
      if (pixel_word[1] != prev[1]) t1++;
      if (pixel_word[2] != prev[2]) t2++;
      if (pixel_word[3] != prev[3]) t3++;
      prev = pixel_word;
    end
    check("R2", 21'(t0), 21'd4);
    check("R3", 21'(t1), 21'd8);
    check("R4", 21'(t2), 21'd16);
    check("R5", 21'(t3), 21'd32);

    // long freeze mid-pattern
    enable = 1'b0; prev = pixel_word;
    for (int i = 0; i < 10; i++) @(negedge clk);
    check("R9", pixel_word, prev);

    finish_run();
  end
endmodule